// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters and picks one entry using a slice of the program counter. A fetch stage gives the predict port an address and gets back a taken or not-taken guess in the same cycle, with no register on the way. When the branch resolves, the update port names the branch address and its real direction. That entry's counter then moves one step toward the outcome and stops at either end of its range.

There are no tags. Any two branches whose address slices match share one counter. Reset loads every counter with the weakest "taken" value, so a branch that has never been seen is predicted taken. On every update the block also compares the stored guess with the real outcome and counts hits and misses, so accuracy can be measured from outside. Index width and counter width are parameters. The defaults are 4096 entries of 2 bits each, which is 1 KB of counter state.

Top module: `bimodal_predictor`

## Requirements
- R1: While reset is held and after it is released, every entry holds the value 2^(CTR_W-1) (binary 10 for 2-bit counters). Every address is therefore predicted taken until that entry is updated.
- R2: `pred_taken` is the most significant bit of the entry selected by `pred_pc`, and it is produced combinationally in the same cycle. For 2-bit counters, 00 and 01 give not-taken, and 10 and 11 give taken.
- R3: A valid update with `upd_taken`=1 adds one to the selected entry. An entry at its maximum (11 for 2 bits) stays at the maximum.
- R4: A valid update with `upd_taken`=0 subtracts one from the selected entry. An entry at 0 stays at 0.
- R5: The entry is selected by `pc[IDX_W+1:2]`. Addresses that differ only in bits [1:0] or in bits above IDX_W+1 use the same counter.
- R6: Starting from the maximum value, one not-taken update leaves the prediction at taken, and a second consecutive not-taken update changes it to not-taken.
- R7: If `pred_pc` and a valid update select the same entry in the same cycle, `pred_taken` shows the value from before that update. The new value is visible after the next rising clock edge.
- R8: In a cycle where `upd_valid` is 0, no entry changes, whatever `upd_pc` and `upd_taken` hold.
- R9: Each valid update increments `hit_count` if the stored most significant bit before the update equals `upd_taken`, and increments `miss_count` otherwise. Exactly one of the two counters moves per valid update.
- R10: Both `hit_count` and `miss_count` read 0 after reset, including a reset applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| hit_count | output | CNT_W | Updates whose stored guess matched the outcome |
| miss_count | output | CNT_W | Updates whose stored guess was wrong |

## Verification
The bench drives counters past both ends of their range. A design that wrapped around would flip from strongly taken to strongly not-taken instead of holding. It steps down from the maximum one outcome at a time. A design that read any bit other than the top one, or that moved two steps, would flip after one not-taken. It also aims addresses that differ only in their low two bits or their high bits at the same entry. A wrong index slice would split those addresses onto separate entries.

Same-entry predict and update in one cycle checks that the guess comes from the old value and is not forwarded. Idle cycles with junk on the update port catch a write that ignores the strobe. A mid-run reset checks that both the table and the hit and miss counters return to their starting values.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Instructions are word aligned: the low address bits carry no information.
  localparam int unsigned ALIGN_BITS = 2;

  // Names for the default 2-bit counter states.
  typedef enum logic [1:0] {
    DIR_STRONG_NT = 2'b00,
    DIR_WEAK_NT   = 2'b01,
    DIR_WEAK_T    = 2'b10,
    DIR_STRONG_T  = 2'b11
  } dir_state_e;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  import bp_pkg::*;
  localparam int unsigned LO = ALIGN_BITS;
  localparam int unsigned HI = ALIGN_BITS + IDX_W - 1;

  generate
    if (HI >= PC_W) begin : g_bad_width
      initial $error("bp_index: IDX_W too wide for PC_W");
      assign idx = '0;
    end else begin : g_slice
      assign idx = pc[HI:LO];
    end
  endgenerate
endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
  parameter int unsigned CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             up,
  output logic [CTR_W-1:0] nxt
);
  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] BOT = '0;
  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  always_comb begin
    nxt = cur;
    if (up) begin
      if (cur != TOP) nxt = cur + ONE;
    end else begin
      if (cur != BOT) nxt = cur - ONE;
    end
  end
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CTR_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CTR_W-1:0] rd_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT_VAL = {1'b1, {(CTR_W-1){1'b0}}};

  logic [DEPTH-1:0][CTR_W-1:0] mem_q;
  logic [DEPTH-1:0][CTR_W-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_VAL;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_a = mem_q[rd_a_idx];
  assign rd_b = mem_q[rd_b_idx];

  // R3 / R4: a write moves an entry by at most one step, never wraps.
  assert_step_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_data} == {1'b0, rd_b}) ||
              ({1'b0, wr_data} == {1'b0, rd_b} + 1'b1) ||
              ({1'b0, wr_data} + 1'b1 == {1'b0, rd_b}));

  // R8: no write strobe, no change anywhere in the table.
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/bp_stats.sv
module bp_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             guess,
  input  logic             actual,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
  logic             is_hit;

  always_comb begin
    is_hit = (guess == actual);
    hit_d  = hit_q;
    miss_d = miss_q;
    if (upd_valid) begin
      if (is_hit) hit_d  = hit_q + ONE;
      else        miss_d = miss_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else if (upd_valid) begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign hit_count  = hit_q;
  assign miss_count = miss_q;

  // R9: each valid update adds exactly one to the combined total.
  assert_one_tally_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hit_q + miss_q) == $past(hit_q + miss_q) + ONE);

  // R9: without an update neither counter moves.
  assert_tally_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hit_q) && $stable(miss_q));
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CTR_W = 2,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic             rst_sync_n;
  logic [IDX_W-1:0] pred_idx, upd_idx;
  logic [CTR_W-1:0] pred_ctr, upd_cur, upd_next;

  bp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_pidx (.pc(pred_pc), .idx(pred_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_uidx (.pc(upd_pc),  .idx(upd_idx));

  bp_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_a_idx (pred_idx),
    .rd_a     (pred_ctr),
    .rd_b_idx (upd_idx),
    .rd_b     (upd_cur),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_data  (upd_next)
  );

  bp_sat_step #(.CTR_W(CTR_W)) u_step (
    .cur (upd_cur),
    .up  (upd_taken),
    .nxt (upd_next)
  );

  bp_stats #(.CNT_W(CNT_W)) u_stats (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd_valid  (upd_valid),
    .guess      (upd_cur[CTR_W-1]),
    .actual     (upd_taken),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  assign pred_taken = pred_ctr[CTR_W-1];

  // R3: a taken outcome holds a saturated counter at the top.
  assert_hold_max_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_taken && upd_cur == CTR_MAX) |-> upd_next == CTR_MAX);

  // R4: a not-taken outcome holds an empty counter at zero.
  assert_hold_min_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && !upd_taken && upd_cur == CTR_MIN) |-> upd_next == CTR_MIN);

  // R7: an update to the predicted entry shows only after the edge.
  assert_old_value_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && pred_idx == upd_idx) |-> pred_taken == upd_cur[CTR_W-1]);
endmodule

// File: tb/bimodal_predictor_tb.sv
`timescale 1ns/1ps
module bimodal_predictor_tb;
  localparam int PC_W = 32, IDX_W = 12, CTR_W = 2, CNT_W = 32;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [PC_W-1:0] pred_pc, upd_pc;
  logic pred_taken, upd_valid, upd_taken;
  logic [CNT_W-1:0] hit_count, miss_count;

  int total = 0, bad = 0, exp_hit = 0, exp_miss = 0;
  int model [DEPTH];
  bit finished = 0;

  always #2.5 clk = ~clk;

  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) & (DEPTH - 1));
  endfunction

  function automatic bit guess_of(input int v);
    return v >= 2;
  endfunction

  function automatic int step_of(input int v, input bit t);
    if (t) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) model[i] = 2;
    exp_hit = 0;
    exp_miss = 0;
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic do_reset();
    rst_n = 1'b0;
    upd_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic peek(input string req, input logic [31:0] pc);
    pred_pc = pc;
    #0.5;
    check(req, pred_taken, guess_of(model[idx_of(pc)]));
  endtask

  task automatic upd(input logic [31:0] pc, input bit t);
    int k;
    k = idx_of(pc);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    if (guess_of(model[k]) == t) exp_hit++; else exp_miss++;
    model[k] = step_of(model[k], t);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd4242));
    pred_pc = '0; upd_pc = '0; upd_taken = 1'b0; upd_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1, R10: reset state
    peek("R1", 32'h0000_0000);
    peek("R1", 32'h0000_3FFC);
    peek("R1", 32'hDEAD_BEEF);
    check("R10", int'(hit_count), 0);
    check("R10", int'(miss_count), 0);

    // R4 and R2: walk down from 10, saturate at 00
    a = 32'h0000_0100;
    upd(a, 1'b0); peek("R2", a);           // 01 -> not taken
    upd(a, 1'b0); peek("R4", a);           // 00
    upd(a, 1'b0); peek("R4", a);           // stays 00
    upd(a, 1'b1); peek("R4", a);           // 01, still not taken if no wrap
    check("R4", pred_taken, 0);
    // R3: climb and saturate
    upd(a, 1'b1); upd(a, 1'b1); upd(a, 1'b1); upd(a, 1'b1);
    peek("R3", a);
    check("R3", pred_taken, 1);
    // R6: from 11, first N keeps taken, second flips
    upd(a, 1'b0); peek("R6", a); check("R6", pred_taken, 1);
    upd(a, 1'b0); peek("R6", a); check("R6", pred_taken, 0);

    // R5: aliasing through low bits and high bits
    a = 32'h0000_0A40;
    upd(a | 32'h3, 1'b0);                  // low bits differ
    upd(a | 32'h0010_4000, 1'b0);          // high bits differ
    peek("R5", a); check("R5", pred_taken, 0);
    peek("R5", a + 32'h4); check("R5", pred_taken, 1); // neighbour untouched

    // R7: same-cycle predict and update
    a = 32'h0000_0200;                     // entry at 10
    pred_pc = a; upd_pc = a; upd_taken = 1'b0; upd_valid = 1'b1;
    #0.5;
    check("R7", pred_taken, 1);
    exp_miss++; model[idx_of(a)] = 1;
    @(posedge clk); @(negedge clk); upd_valid = 1'b0;
    #0.5;
    check("R7", pred_taken, 0);

    // R8: junk on update port with strobe low
    a = 32'h0000_0300;
    upd_pc = a; upd_taken = 1'b0; upd_valid = 1'b0;
    repeat (4) @(negedge clk);
    peek("R8", a); check("R8", pred_taken, 1);
    check("R8", int'(hit_count), exp_hit);

    // Random mix: R2, R5, R7, R9
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pp, up;
      bit t;
      @(negedge clk);
      pp = (($urandom_range(0, 7) * 37) << 2) | ($urandom & 32'hFFF0_0003);
      up = (($urandom_range(0, 7) * 37) << 2) | ($urandom & 32'hFFF0_0003);
      t = ($urandom_range(0, 9) < 6);
      pred_pc = pp; upd_pc = up; upd_taken = t;
      upd_valid = ($urandom_range(0, 3) != 0);
      #0.5;
      check("R2", pred_taken, guess_of(model[idx_of(pp)]));
      if (upd_valid) begin
        if (guess_of(model[idx_of(up)]) == t) exp_hit++; else exp_miss++;
        model[idx_of(up)] = step_of(model[idx_of(up)], t);
      end
    end
    @(negedge clk); upd_valid = 1'b0;
    @(negedge clk);
    check("R9", int'(hit_count), exp_hit);
    check("R9", int'(miss_count), exp_miss);

    // R10 / R1: reset in the middle of operation
    do_reset();
    check("R10", int'(hit_count), 0);
    check("R10", int'(miss_count), 0);
    peek("R1", 32'h0000_0100);
    peek("R1", 32'h0000_0A40);
    check("R1", pred_taken, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule